// File: doc/BRIEF.md
# Two-Level 32-bit Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level page table made of 32-bit entries. A walk starts with a one-cycle `start_i` pulse while the walker is idle. The walker takes the virtual address, the page-table root frame, the page-size-extension enable and the load/store type of the access. It reads the directory entry and, for a small page, the table entry through a request/acknowledge memory port. It finishes with a one-cycle `done_o` pulse that carries either a translation or a fault.

Directory entries with the page-size bit (bit 7) set map a 4 MB page when page-size extension is enabled. Such an entry carries physical address bits 39..32 in its bits 20..13. Otherwise every directory entry points to a second-level table and the leaf is a 4 KB page. Accessed (bit 5) and dirty (bit 6) flags are maintained with compare-and-swap operations on the same port. A swap that loses to another writer is retried as described below. Permission decisions, no-execute handling and translation caching belong to neighbouring blocks. This block only returns the combined user and write attributes.

Top module: `ptw32_walker`

## Requirements
- R1: The directory entry is read at `{root_frame_i, vaddr[31:22], 2'b00}`. The table entry is read at `{directory[31:12], vaddr[21:12], 2'b00}`.
- R2: An entry with bit 0 clear, at either level, ends the walk with `fault_o`=1 and `fault_kind_o`=0. On any fault `paddr_o`, `big_page_o`, `user_o` and `write_o` are all 0.
- R3: With `pse_en_i`=1, a present directory entry with bit 7 set is a 4 MB leaf. It gives `big_page_o`=1 and `paddr_o` = `{entry[20:13], entry[31:22], vaddr[21:0]}`. With `pse_en_i`=0, bit 7 is ignored and the entry points to a table.
- R4: A 4 MB leaf with bit 21 set ends with `fault_o`=1 and `fault_kind_o`=1, and no swap is issued.
- R5: On the table path, a directory entry with bit 5 clear is swapped to have bit 5 set before the table read. A failed swap re-reads the directory entry.
- R6: `user_o` is the AND of bit 2 of the directory and table entries, and the base write attribute is the AND of their bits 1. For a 4 MB leaf both come from the directory entry alone.
- R7: At the leaf the walker makes bit 5 set, plus bit 6 on a store. It issues a swap only if one of these bits is missing, and a swap only ever sets bits. A failed leaf swap restarts the walk at the directory read.
- R8: `write_o` is the base write attribute, cleared on a load whose leaf entry had bit 6 clear.
- R9: A 4 KB translation gives `paddr_o` = `{8'h00, pte[31:12], vaddr[11:0]}` and `big_page_o`=0.
- R10: `done_o` is a single-cycle pulse with `busy_o` low. `start_i` while `busy_o` is high is ignored.
- R11: `mem_req_o` is asserted only while busy, and address, opcode and data stay stable until `mem_ack_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a walk (taken only when idle) |
| vaddr_i | input | 32 | Virtual address |
| root_frame_i | input | 20 | Frame number of the directory |
| pse_en_i | input | 1 | Allow 4 MB leaves |
| store_i | input | 1 | Access is a store |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result valid for one cycle |
| fault_o | output | 1 | Walk ended in a fault |
| fault_kind_o | output | 1 | 0 not present, 1 reserved bit |
| paddr_o | output | 40 | Translated physical address |
| big_page_o | output | 1 | Leaf is a 4 MB page |
| user_o | output | 1 | Combined user attribute |
| write_o | output | 1 | Write attribute after dirty rule |
| mem_req_o | output | 1 | Memory request |
| mem_cas_o | output | 1 | Request is compare-and-swap, else read |
| mem_addr_o | output | 32 | Entry address |
| mem_cmp_o | output | 32 | Swap compare value |
| mem_wdata_o | output | 32 | Swap new value |
| mem_ack_i | input | 1 | Request completed |
| mem_rdata_i | input | 32 | Read data |
| mem_cas_ok_i | input | 1 | Swap took effect |

## Verification
A stale or corrupted entry register shows up first on the memory port. The next request carries a wrong address or a wrong compare value, one cycle after the bad state is loaded. It then shows in the memory image left behind, where flags are missing or sit in the wrong entry. A wrong state transition appears as an extra or missing request, so the per-walk request count differs from the model. It can also appear as a done pulse with no walk pending. Attribute and offset mistakes surface only at the done pulse, in `paddr_o`, `user_o` and `write_o`.

// File: rtl/ptw32_pkg.sv
package ptw32_pkg;
  localparam int unsigned P_BIT   = 0;
  localparam int unsigned RW_BIT  = 1;
  localparam int unsigned US_BIT  = 2;
  localparam int unsigned A_BIT   = 5;
  localparam int unsigned D_BIT   = 6;
  localparam int unsigned PS_BIT  = 7;
  localparam int unsigned HI_LSB  = 13;
  localparam int unsigned RSV_BIT = 21;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DIR_RD,
    ST_DIR_CAS,
    ST_TBL_RD,
    ST_LEAF_CHK,
    ST_LEAF_CAS
  } walk_st_e;

  typedef enum logic {
    FLT_NOT_PRESENT = 1'b0,
    FLT_RESERVED    = 1'b1
  } flt_e;
endpackage

// File: rtl/ptw32_addr_gen.sv
module ptw32_addr_gen #(
  parameter int unsigned FRAME_W = 20,
  parameter int unsigned IDX_W   = 10,
  localparam int unsigned ADDR_W = FRAME_W + IDX_W + 2
) (
  input  logic [FRAME_W-1:0] root_frame_i,
  input  logic [IDX_W-1:0]   dir_idx_i,
  input  logic [FRAME_W-1:0] tbl_frame_i,
  input  logic [IDX_W-1:0]   tbl_idx_i,
  output logic [ADDR_W-1:0]  dir_addr_o,
  output logic [ADDR_W-1:0]  tbl_addr_o
);
  // 4-byte entries: index scaled by 4
  assign dir_addr_o = {root_frame_i, dir_idx_i, 2'b00};
  assign tbl_addr_o = {tbl_frame_i, tbl_idx_i, 2'b00};
endmodule

// File: rtl/ptw32_leaf_ctl.sv
module ptw32_leaf_ctl
  import ptw32_pkg::*;
#(
  parameter int unsigned ENT_W = 32
) (
  input  logic [ENT_W-1:0] leaf_i,
  input  logic             store_i,
  input  logic             wr_base_i,
  output logic [ENT_W-1:0] leaf_new_o,
  output logic             need_cas_o,
  output logic             write_o
);
  logic [ENT_W-1:0] set_mask;

  always_comb begin
    set_mask = '0;
    set_mask[A_BIT] = 1'b1;
    set_mask[D_BIT] = store_i;
  end

  assign leaf_new_o = leaf_i | set_mask;
  assign need_cas_o = |(set_mask & ~leaf_i);
  // a load on a clean page must fault again on the first store
  assign write_o    = wr_base_i & (store_i | leaf_i[D_BIT]);
endmodule

// File: rtl/ptw32_pa_merge.sv
module ptw32_pa_merge #(
  parameter int unsigned HI_W        = 8,
  parameter int unsigned FRAME_W     = 20,
  parameter int unsigned BIG_FRAME_W = 10,
  parameter int unsigned OFF_W       = 12,
  parameter int unsigned BIG_OFF_W   = 22,
  localparam int unsigned PA_W       = HI_W + FRAME_W + OFF_W
) (
  input  logic                   big_i,
  input  logic [FRAME_W-1:0]     frame_small_i,
  input  logic [BIG_FRAME_W-1:0] frame_big_i,
  input  logic [HI_W-1:0]        hi_i,
  input  logic [BIG_OFF_W-1:0]   off_i,
  output logic [PA_W-1:0]        paddr_o
);
  logic [PA_W-1:0] pa_small, pa_big;

  assign pa_small = {{HI_W{1'b0}}, frame_small_i, off_i[OFF_W-1:0]};
  assign pa_big   = {hi_i, frame_big_i, off_i};
  assign paddr_o  = big_i ? pa_big : pa_small;
endmodule

// File: rtl/ptw32_walker.sv
module ptw32_walker
  import ptw32_pkg::*;
#(
  parameter int unsigned ENT_W = 32,
  parameter int unsigned PA_W  = 40,
  parameter int unsigned OFF_W = 12,
  parameter int unsigned IDX_W = 10,
  localparam int unsigned FRAME_W     = ENT_W - OFF_W,
  localparam int unsigned BIG_OFF_W   = OFF_W + IDX_W,
  localparam int unsigned BIG_FRAME_W = ENT_W - BIG_OFF_W,
  localparam int unsigned HI_W        = PA_W - ENT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [ENT_W-1:0]   vaddr_i,
  input  logic [FRAME_W-1:0] root_frame_i,
  input  logic               pse_en_i,
  input  logic               store_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               fault_o,
  output logic               fault_kind_o,
  output logic [PA_W-1:0]    paddr_o,
  output logic               big_page_o,
  output logic               user_o,
  output logic               write_o,
  output logic               mem_req_o,
  output logic               mem_cas_o,
  output logic [ENT_W-1:0]   mem_addr_o,
  output logic [ENT_W-1:0]   mem_cmp_o,
  output logic [ENT_W-1:0]   mem_wdata_o,
  input  logic               mem_ack_i,
  input  logic [ENT_W-1:0]   mem_rdata_i,
  input  logic               mem_cas_ok_i
);
  walk_st_e           state_q;
  logic [ENT_W-1:0]   va_q;
  logic [FRAME_W-1:0] root_q;
  logic               pse_q, store_q;
  logic [ENT_W-1:0]   pde_q, leaf_q, leaf_addr_q;
  logic               big_q, usr_q, wr_q;

  logic               done_q, fault_q, kind_q, bigo_q, usro_q, wro_q;
  logic [PA_W-1:0]    pa_q;

  logic [ENT_W-1:0]   dir_addr, tbl_addr, leaf_new, pde_acc;
  logic               leaf_need, leaf_wr;
  logic [PA_W-1:0]    pa_merged;
  logic               rd_present, rd_big, rd_rsvd, rd_acc;
  logic               fin_ok, fin_flt;
  flt_e               fin_kind;

  ptw32_addr_gen #(.FRAME_W(FRAME_W), .IDX_W(IDX_W)) i_addr_gen (
    .root_frame_i (root_q),
    .dir_idx_i    (va_q[ENT_W-1 -: IDX_W]),
    .tbl_frame_i  (pde_q[ENT_W-1:OFF_W]),
    .tbl_idx_i    (va_q[OFF_W +: IDX_W]),
    .dir_addr_o   (dir_addr),
    .tbl_addr_o   (tbl_addr)
  );

  ptw32_leaf_ctl #(.ENT_W(ENT_W)) i_leaf_ctl (
    .leaf_i     (leaf_q),
    .store_i    (store_q),
    .wr_base_i  (wr_q),
    .leaf_new_o (leaf_new),
    .need_cas_o (leaf_need),
    .write_o    (leaf_wr)
  );

  ptw32_pa_merge #(
    .HI_W(HI_W), .FRAME_W(FRAME_W), .BIG_FRAME_W(BIG_FRAME_W),
    .OFF_W(OFF_W), .BIG_OFF_W(BIG_OFF_W)
  ) i_pa_merge (
    .big_i         (big_q),
    .frame_small_i (leaf_q[ENT_W-1:OFF_W]),
    .frame_big_i   (leaf_q[ENT_W-1:BIG_OFF_W]),
    .hi_i          (leaf_q[HI_LSB +: HI_W]),
    .off_i         (va_q[BIG_OFF_W-1:0]),
    .paddr_o       (pa_merged)
  );

  always_comb begin
    rd_present = mem_rdata_i[P_BIT];
    rd_big     = mem_rdata_i[PS_BIT] & pse_q;
    rd_rsvd    = mem_rdata_i[RSV_BIT];
    rd_acc     = mem_rdata_i[A_BIT];
    pde_acc    = pde_q;
    pde_acc[A_BIT] = 1'b1;
  end

  // memory port, driven purely from state
  always_comb begin
    mem_req_o   = 1'b0;
    mem_cas_o   = 1'b0;
    mem_addr_o  = '0;
    mem_cmp_o   = '0;
    mem_wdata_o = '0;
    unique case (state_q)
      ST_DIR_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = dir_addr;
      end
      ST_DIR_CAS: begin
        mem_req_o   = 1'b1;
        mem_cas_o   = 1'b1;
        mem_addr_o  = dir_addr;
        mem_cmp_o   = pde_q;
        mem_wdata_o = pde_acc;
      end
      ST_TBL_RD: begin
        mem_req_o  = 1'b1;
        mem_addr_o = tbl_addr;
      end
      ST_LEAF_CAS: begin
        mem_req_o   = 1'b1;
        mem_cas_o   = 1'b1;
        mem_addr_o  = leaf_addr_q;
        mem_cmp_o   = leaf_q;
        mem_wdata_o = leaf_new;
      end
      default: ;
    endcase
  end

  always_comb begin
    fin_ok   = ((state_q == ST_LEAF_CHK) && !leaf_need) ||
               ((state_q == ST_LEAF_CAS) && mem_ack_i && mem_cas_ok_i);
    fin_flt  = ((state_q == ST_DIR_RD) && mem_ack_i && (!rd_present || (rd_big && rd_rsvd))) ||
               ((state_q == ST_TBL_RD) && mem_ack_i && !rd_present);
    fin_kind = ((state_q == ST_DIR_RD) && rd_present) ? FLT_RESERVED : FLT_NOT_PRESENT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      va_q        <= '0;
      root_q      <= '0;
      pse_q       <= 1'b0;
      store_q     <= 1'b0;
      pde_q       <= '0;
      leaf_q      <= '0;
      leaf_addr_q <= '0;
      big_q       <= 1'b0;
      usr_q       <= 1'b0;
      wr_q        <= 1'b0;
    end else if (fin_ok || fin_flt) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          va_q    <= vaddr_i;
          root_q  <= root_frame_i;
          pse_q   <= pse_en_i;
          store_q <= store_i;
          state_q <= ST_DIR_RD;
        end
        ST_DIR_RD: if (mem_ack_i) begin
          pde_q <= mem_rdata_i;
          if (rd_big) begin
            leaf_q      <= mem_rdata_i;
            leaf_addr_q <= dir_addr;
            big_q       <= 1'b1;
            usr_q       <= mem_rdata_i[US_BIT];
            wr_q        <= mem_rdata_i[RW_BIT];
            state_q     <= ST_LEAF_CHK;
          end else begin
            state_q <= rd_acc ? ST_TBL_RD : ST_DIR_CAS;
          end
        end
        ST_DIR_CAS: if (mem_ack_i) begin
          if (mem_cas_ok_i) begin
            pde_q   <= pde_acc;
            state_q <= ST_TBL_RD;
          end else begin
            state_q <= ST_DIR_RD;
          end
        end
        ST_TBL_RD: if (mem_ack_i) begin
          leaf_q      <= mem_rdata_i;
          leaf_addr_q <= tbl_addr;
          big_q       <= 1'b0;
          usr_q       <= pde_q[US_BIT] & mem_rdata_i[US_BIT];
          wr_q        <= pde_q[RW_BIT] & mem_rdata_i[RW_BIT];
          state_q     <= ST_LEAF_CHK;
        end
        ST_LEAF_CHK: state_q <= ST_LEAF_CAS;
        // lost the race: any level may have changed, start over
        ST_LEAF_CAS: if (mem_ack_i) state_q <= ST_DIR_RD;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      kind_q  <= 1'b0;
      pa_q    <= '0;
      bigo_q  <= 1'b0;
      usro_q  <= 1'b0;
      wro_q   <= 1'b0;
    end else begin
      done_q <= fin_ok | fin_flt;
      if (fin_ok) begin
        fault_q <= 1'b0;
        kind_q  <= 1'b0;
        pa_q    <= pa_merged;
        bigo_q  <= big_q;
        usro_q  <= usr_q;
        wro_q   <= leaf_wr;
      end else if (fin_flt) begin
        fault_q <= 1'b1;
        kind_q  <= fin_kind;
        pa_q    <= '0;
        bigo_q  <= 1'b0;
        usro_q  <= 1'b0;
        wro_q   <= 1'b0;
      end
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign fault_o      = fault_q;
  assign fault_kind_o = kind_q;
  assign paddr_o      = pa_q;
  assign big_page_o   = bigo_q;
  assign user_o       = usro_q;
  assign write_o      = wro_q;
endmodule

// File: rtl/ptw32_walker_chk.sv
module ptw32_walker_chk #(
  parameter int unsigned ENT_W = 32,
  parameter int unsigned PA_W  = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             busy_o,
  input logic [ENT_W-1:0] vaddr_i,
  input logic             done_o,
  input logic             fault_o,
  input logic             big_page_o,
  input logic [PA_W-1:0]  paddr_o,
  input logic             mem_req_o,
  input logic             mem_cas_o,
  input logic [ENT_W-1:0] mem_addr_o,
  input logic [ENT_W-1:0] mem_cmp_o,
  input logic [ENT_W-1:0] mem_wdata_o,
  input logic             mem_ack_i
);
  logic [ENT_W-1:0] va_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) va_seen <= '0;
    else if (start_i && !busy_o) va_seen <= vaddr_i;
  end

  a_r1_dir_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (mem_req_o && !mem_cas_o &&
                              mem_addr_o[11:2] == $past(vaddr_i[31:22])));

  a_r2_fault_clean: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && fault_o) |-> (paddr_o == '0 && !big_page_o));

  a_r3_big_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o && big_page_o) |-> (paddr_o[21:0] == va_seen[21:0]));

  a_r9_small_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !fault_o && !big_page_o) |-> (paddr_o[11:0] == va_seen[11:0]));

  a_r7_swap_sets_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_cas_o) |-> (((mem_cmp_o & ~mem_wdata_o) == '0) &&
                                  (mem_wdata_o != mem_cmp_o)));

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                   $stable(mem_cas_o) && $stable(mem_wdata_o)));

  a_r11_req_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

bind ptw32_walker ptw32_walker_chk #(.ENT_W(ENT_W), .PA_W(PA_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .vaddr_i     (vaddr_i),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .big_page_o  (big_page_o),
  .paddr_o     (paddr_o),
  .mem_req_o   (mem_req_o),
  .mem_cas_o   (mem_cas_o),
  .mem_addr_o  (mem_addr_o),
  .mem_cmp_o   (mem_cmp_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i)
);

// File: tb/test_ptw32_walker.sv
`timescale 1ns/1ps
module test_ptw32_walker;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] vaddr_i = '0;
  logic [19:0] root_frame_i = 20'h00010;
  logic        pse_en_i = 1'b0;
  logic        store_i = 1'b0;
  logic        busy_o, done_o, fault_o, fault_kind_o, big_page_o, user_o, write_o;
  logic [39:0] paddr_o;
  logic        mem_req_o, mem_cas_o;
  logic [31:0] mem_addr_o, mem_cmp_o, mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_cas_ok_i = 1'b0;

  always #4ns clk_i = ~clk_i;

  ptw32_walker i_ptw32_walker (
    .clk_i, .rst_ni, .start_i, .vaddr_i, .root_frame_i, .pse_en_i, .store_i,
    .busy_o, .done_o, .fault_o, .fault_kind_o, .paddr_o, .big_page_o,
    .user_o, .write_o, .mem_req_o, .mem_cas_o, .mem_addr_o, .mem_cmp_o,
    .mem_wdata_o, .mem_ack_i, .mem_rdata_i, .mem_cas_ok_i
  );

  logic [31:0] dmem    [logic [31:0]];
  logic [31:0] ref_mem [logic [31:0]];
  int dut_fail = 0, ref_fail = 0;
  int n_chk = 0, n_fail = 0;
  int ops_seen = 0, done_cnt = 0, viol = 0;
  bit pending = 0, abort = 0;
  logic        c_fault, c_kind, c_big, c_user, c_write;
  logic [39:0] c_pa;

  function automatic logic [31:0] rd_dut(logic [31:0] a);
    return dmem.exists(a) ? dmem[a] : 32'h0;
  endfunction
  function automatic logic [31:0] rd_ref(logic [31:0] a);
    return ref_mem.exists(a) ? ref_mem[a] : 32'h0;
  endfunction

  task automatic put(logic [31:0] a, logic [31:0] v);
    dmem[a] = v;
    ref_mem[a] = v;
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // memory responder: one request per ack, ack held one cycle
  initial begin
    logic [31:0] cur;
    logic ok;
    forever begin
      @(negedge clk_i);
      if (mem_ack_i) mem_ack_i = 1'b0;
      else if (rst_ni && mem_req_o) begin
        ops_seen++;
        if (mem_cas_o) begin
          cur = rd_dut(mem_addr_o);
          ok = (cur == mem_cmp_o);
          if (dut_fail > 0) begin dut_fail--; ok = 1'b0; end
          if (ok) dmem[mem_addr_o] = mem_wdata_o;
          mem_cas_ok_i = ok;
        end else begin
          mem_rdata_i = rd_dut(mem_addr_o);
        end
        mem_ack_i = 1'b1;
      end
    end
  end

  // per-clock monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (rst_ni) begin
        if (done_o) begin
          done_cnt++;
          c_fault = fault_o; c_kind = fault_kind_o; c_pa = paddr_o;
          c_big = big_page_o; c_user = user_o; c_write = write_o;
          if (!pending) viol++;
        end
        if (mem_req_o && !busy_o) viol++;
      end
    end
  end

  // behavioural reference walk on ref_mem
  task automatic ref_walk(input logic [31:0] va, input logic pse, input logic st,
                          output logic flt, output logic kind, output logic [39:0] pa,
                          output logic big, output logic usr, output logic wr,
                          output int ops);
    logic [31:0] da, ta, pde, pte, leaf, la, setm;
    logic fin, have, u, w;
    ops = 0; fin = 0; flt = 0; kind = 0; pa = '0; big = 0; usr = 0; wr = 0;
    leaf = '0; la = '0; u = 0; w = 0;
    while (!fin) begin
      have = 0;
      da = {root_frame_i, va[31:22], 2'b00};
      pde = rd_ref(da); ops++;
      if (!pde[0]) begin flt = 1; kind = 0; fin = 1; end
      else if (pde[7] && pse) begin
        if (pde[21]) begin flt = 1; kind = 1; fin = 1; end
        else begin leaf = pde; la = da; big = 1; u = pde[2]; w = pde[1]; have = 1; end
      end else begin
        if (!pde[5]) begin
          ops++;
          if (ref_fail > 0) begin ref_fail--; continue; end
          pde = pde | 32'h20;
          ref_mem[da] = pde;
        end
        ta = {pde[31:12], va[21:12], 2'b00};
        pte = rd_ref(ta); ops++;
        if (!pte[0]) begin flt = 1; kind = 0; fin = 1; end
        else begin leaf = pte; la = ta; big = 0; u = pde[2] & pte[2]; w = pde[1] & pte[1]; have = 1; end
      end
      if (have) begin
        setm = st ? 32'h60 : 32'h20;
        if ((leaf & setm) != setm) begin
          ops++;
          if (ref_fail > 0) begin ref_fail--; big = 0; continue; end
          ref_mem[la] = leaf | setm;
        end
        fin = 1;
        usr = u;
        wr = w & (st | leaf[6]);
        pa = big ? {leaf[20:13], leaf[31:22], va[21:0]} : {8'h00, leaf[31:12], va[11:0]};
      end
    end
  endtask

  task automatic run_walk(string tag, logic [31:0] va, logic pse, logic st, bit extra);
    logic e_flt, e_kind, e_big, e_usr, e_wr;
    logic [39:0] e_pa;
    int e_ops, cyc, mism;
    if (abort) return;
    ref_walk(va, pse, st, e_flt, e_kind, e_pa, e_big, e_usr, e_wr, e_ops);
    done_cnt = 0; ops_seen = 0; viol = 0; pending = 1;
    @(negedge clk_i);
    start_i = 1'b1; vaddr_i = va; pse_en_i = pse; store_i = st;
    @(negedge clk_i);
    start_i = 1'b0;
    if (extra) begin
      @(negedge clk_i);
      start_i = 1'b1; vaddr_i = ~va; store_i = ~st;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    cyc = 0;
    while (done_cnt == 0 && cyc < 2000) begin @(negedge clk_i); cyc++; end
    if (done_cnt == 0) begin
      chk({tag, " watchdog R10 walk finished"}, 0, 1);
      abort = 1;
      return;
    end
    repeat (4) @(negedge clk_i);
    pending = 0;
    chk({tag, " R10 single done pulse"}, done_cnt, 1);
    chk({tag, " R2 R4 fault flag"}, c_fault, e_flt);
    chk({tag, " R2 R4 fault kind"}, c_kind, e_kind);
    chk({tag, " R1 R3 R9 paddr"}, c_pa, e_pa);
    chk({tag, " R3 big page"}, c_big, e_big);
    chk({tag, " R6 user"}, c_user, e_usr);
    chk({tag, " R6 R8 write"}, c_write, e_wr);
    chk({tag, " R5 R7 memory op count"}, ops_seen, e_ops);
    chk({tag, " R11 protocol"}, viol, 0);
    mism = 0;
    foreach (ref_mem[k]) if (rd_dut(k) !== ref_mem[k]) mism++;
    chk({tag, " R7 memory image"}, mism, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R10 reset done", done_o, 0);
    chk("R10 reset busy", busy_o, 0);
    chk("R11 reset req", mem_req_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // directory at 0x10000
    put(32'h0001_0004, 32'h0002_0007);  put(32'h0002_000C, 32'h0055_5007);
    put(32'h0001_000C, 32'h0003_0003);
    put(32'h0001_0010, 32'h0854_A085);  put(32'h0854_A000, 32'h0077_7005);
    put(32'h0001_0014, 32'h08A0_0083);
    put(32'h0001_0018, 32'h0004_0005);  put(32'h0004_0008, 32'h0088_8067);
    put(32'h0001_001C, 32'h0005_0003);  put(32'h0005_0000, 32'h0099_9003);
    put(32'h0001_0020, 32'h0006_0027);  put(32'h0006_0000, 32'h00AA_A003);

    run_walk("4k load clean",       32'h0040_3123, 1'b1, 1'b0, 0);  // R5 R8
    run_walk("4k store",            32'h0040_3FFF, 1'b1, 1'b1, 0);  // R7
    run_walk("4k store dirty",      32'h0040_3000, 1'b1, 1'b1, 0);
    run_walk("dir not present",     32'h0080_0456, 1'b1, 1'b0, 0);  // R2
    run_walk("tbl not present",     32'h00C0_5010, 1'b1, 1'b1, 0);  // R2
    run_walk("4m load",             32'h0100_0ABC, 1'b1, 1'b0, 0);  // R3
    run_walk("4m store",            32'h013F_FFFF, 1'b1, 1'b1, 0);  // R3 R7
    run_walk("ps ignored w/o pse",  32'h0100_0ABC, 1'b0, 1'b0, 0);  // R3
    run_walk("4m reserved bit",     32'h0140_0001, 1'b1, 1'b1, 0);  // R4
    run_walk("attr and",            32'h0180_2345, 1'b1, 1'b1, 0);  // R6
    dut_fail = 1; ref_fail = 1;
    run_walk("dir swap fails",      32'h01C0_0777, 1'b1, 1'b0, 0);  // R5
    dut_fail = 1; ref_fail = 1;
    run_walk("leaf swap fails",     32'h0200_0888, 1'b1, 1'b1, 0);  // R7
    run_walk("start while busy",    32'h0040_3ABC, 1'b1, 1'b0, 1);  // R10

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule